// File: doc/BRIEF.md
# Redundant-Thread Log Buffer Controller

This block keeps a circular log that a leading (master) thread and a trailing (slave) thread share while they run the same code redundantly. Each memory operation the master commits is appended to the log. A load stores its address and the value it read. A store stores its address and the memory value it overwrote, so that a rollback can restore that value. The value being written is never logged. The slave reads the log back in program order. Its loads are served from the log through the slave read pointer, so they see exactly the values the master saw. Its stores touch neither memory nor the log; they only step the read pointer past the matching entry.

Execution is split into chunks. The master closes a chunk with a commit strobe, and up to `NUM_SLOTS` committed chunks may wait for the slave to verify them. Committing a chunk keeps its log entries. Only a verify of the oldest chunk releases its entries, by moving the log tail to the start marker of the following chunk. The master therefore runs several chunks ahead, and the log wraps around the ring. The master stalls when the ring is full or when every chunk slot is taken. An abort throws away all in-flight chunks.

Top module: `rlog_buffer`

## Requirements
- R1: An accepted master load writes an entry holding its address, its value and a kind flag of 0. The slave load that consumes this entry has `sValid`=1 and returns the value on `sValue` one clock after the request.
- R2: An accepted master store writes an entry holding its address, the old value and a kind flag of 1. A slave store gives no `sValid` and returns no data, and it advances the read pointer past exactly one entry.
- R3: The slave consumes entries in the order the master appended them, including across chunk boundaries.
- R4: `sStall`=1 whenever every entry of all committed chunks has been consumed. Entries of the open, uncommitted chunk are not readable.
- R5: Committing a chunk frees no log space. With `LOG_DEPTH` entries unverified, `mStall`=1 even if all of them belong to committed chunks, and reading them does not clear the stall.
- R6: `sVerify` releases the entries of the oldest committed chunk. This frees ring space and clears a full-log stall.
- R7: After `NUM_SLOTS` commits with no verify, `mStall`=1. Appends and commits offered while `mStall`=1 are ignored.
- R8: `sMismatch`=1 together with `sValid` when the slave load address differs from the logged address, or when the consumed entry is a store. Otherwise `sMismatch`=0.
- R9: `sAbort` discards every in-flight entry and chunk. One clock later `sStall`=1 and `mStall`=0, and the next entries are read from the point where the log was restarted.
- R10: After reset `mStall`=0, `sStall`=1 and `sValid`=0.
- R11: The write and read pointers wrap around the ring, and entries written after a wrap read back correctly.
- R12: A slave request while `sStall`=1 is ignored: it gives no `sValid` and does not move the read pointer.
- R13: `sVerify` with no committed chunk is ignored and leaves the chunk count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mAppend | input | 1 | Master commits one memory operation |
| mIsStore | input | 1 | 1 = the master operation is a store |
| mAddr | input | ADDR_W | Master operation address |
| mValue | input | DATA_W | Loaded value (load) or overwritten value (store) |
| mCommit | input | 1 | Close the current master chunk |
| mStall | output | 1 | Master must hold: log full or all slots in use |
| sReq | input | 1 | Slave memory operation request |
| sIsStore | input | 1 | 1 = the slave operation is a store |
| sAddr | input | ADDR_W | Slave load address, compared with the log |
| sValid | output | 1 | Logged value for a slave load is on `sValue` |
| sValue | output | DATA_W | Value returned to the slave load |
| sMismatch | output | 1 | Slave load diverged from the log entry |
| sStall | output | 1 | No committed entry is left to read |
| sVerify | input | 1 | Oldest committed chunk verified; release its entries |
| sAbort | input | 1 | Discard all in-flight chunks |

## Verification
The checker assumes that the slave raises `sVerify` only after it has consumed the oldest chunk's entries. It also assumes that verify and abort never release more than was committed; the block ignores a verify with no chunk, which keeps the count safe. The directed stimulus keeps this ordering: every chunk is read in full before it is verified. Stalled-side stimulus, such as appends while `mStall` is high or reads while `sStall` is high, is offered on purpose, because the properties demand that it leave no trace. Abort is used only to clean up between scenarios and to check that reading restarts where the log restarts.

// File: rtl/rlog_pkg.sv
package rlog_pkg;
  // strobes from control to the log datapath
  typedef struct packed {
    logic logWrite;   // store one master entry
    logic slaveLoad;  // read one entry for a slave load
  } logStrobe_t;
endpackage

// File: rtl/rlog_ctrl.sv
module rlog_ctrl
  import rlog_pkg::*;
#(
  parameter int LOG_DEPTH = 16,
  parameter int NUM_SLOTS = 5,
  localparam int IDX_W  = $clog2(LOG_DEPTH),
  localparam int PTR_W  = IDX_W + 1,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mAppend,
  input  logic             mCommit,
  input  logic             sReq,
  input  logic             sIsStore,
  input  logic             sVerify,
  input  logic             sAbort,
  output logic             mStall,
  output logic             sStall,
  output logStrobe_t       strobe,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx
);

  logic [PTR_W-1:0] wrPtr, rdPtr, tailPtr, openStart;
  logic [PTR_W-1:0] slotStart [NUM_SLOTS];
  logic [SLOT_W-1:0] headSlot, tailSlot;
  logic [CNT_W-1:0] chunkCnt;

  logic logFull, slotsFull, wrGo, commitGo, verifyGo, sGo;
  logic [PTR_W-1:0] nextStart;

  function automatic logic [SLOT_W-1:0] slotInc(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(NUM_SLOTS - 1)) ? '0 : s + SLOT_W'(1);
  endfunction

  // ring is full when the pointers differ only in the wrap bit
  assign logFull   = (wrPtr[IDX_W] != tailPtr[IDX_W]) &&
                     (wrPtr[IDX_W-1:0] == tailPtr[IDX_W-1:0]);
  assign slotsFull = (chunkCnt == CNT_W'(NUM_SLOTS));
  assign mStall    = logFull || slotsFull;
  // the slave may read only up to the start of the open chunk
  assign sStall    = (rdPtr == openStart);

  assign wrGo     = mAppend && !mStall && !sAbort;
  assign commitGo = mCommit && !mStall && !sAbort;
  assign verifyGo = sVerify && !sAbort && (chunkCnt != '0);
  assign sGo      = sReq && !sStall && !sAbort;

  // start of the chunk after the oldest one; the open chunk when only one is pending
  assign nextStart = (chunkCnt > CNT_W'(1)) ? slotStart[slotInc(tailSlot)] : openStart;

  assign strobe.logWrite  = wrGo;
  assign strobe.slaveLoad = sGo && !sIsStore;
  assign wrIdx = wrPtr[IDX_W-1:0];
  assign rdIdx = rdPtr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      tailPtr   <= '0;
      openStart <= '0;
      headSlot  <= '0;
      tailSlot  <= '0;
      chunkCnt  <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) slotStart[i] <= '0;
    end else if (sAbort) begin
      wrPtr     <= tailPtr;
      rdPtr     <= tailPtr;
      openStart <= tailPtr;
      headSlot  <= tailSlot;
      chunkCnt  <= '0;
    end else begin
      if (wrGo) wrPtr <= wrPtr + PTR_W'(1);
      if (commitGo) begin
        slotStart[headSlot] <= openStart;
        headSlot            <= slotInc(headSlot);
        openStart           <= wrPtr + (wrGo ? PTR_W'(1) : PTR_W'(0));
      end
      if (sGo) rdPtr <= rdPtr + PTR_W'(1);
      if (verifyGo) begin
        tailPtr  <= nextStart;
        tailSlot <= slotInc(tailSlot);
      end
      chunkCnt <= chunkCnt + CNT_W'(commitGo) - CNT_W'(verifyGo);
    end
  end

endmodule

// File: rtl/rlog_datapath.sv
module rlog_datapath
  import rlog_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int LOG_DEPTH = 16,
  localparam int IDX_W = $clog2(LOG_DEPTH),
  localparam int ENT_W = 1 + ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic              mIsStore,
  input  logic [ADDR_W-1:0] mAddr,
  input  logic [DATA_W-1:0] mValue,
  input  logic [ADDR_W-1:0] sAddr,
  output logic              sValid,
  output logic [DATA_W-1:0] sValue,
  output logic              sMismatch
);

  // entry layout: {kind, address, value}, kind 1 = store
  logic [ENT_W-1:0] logMem [LOG_DEPTH];
  logic [ENT_W-1:0] rdEntry;
  logic             entKind;
  logic [ADDR_W-1:0] entAddr;
  logic [DATA_W-1:0] entValue;

  always_ff @(posedge clk) begin
    if (strobe.logWrite) logMem[wrIdx] <= {mIsStore, mAddr, mValue};
  end

  assign rdEntry = logMem[rdIdx];
  assign {entKind, entAddr, entValue} = rdEntry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sValid    <= 1'b0;
      sValue    <= '0;
      sMismatch <= 1'b0;
    end else begin
      sValid <= strobe.slaveLoad;
      if (strobe.slaveLoad) begin
        sValue    <= entValue;
        sMismatch <= entKind || (entAddr != sAddr);
      end else begin
        sMismatch <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rlog_buffer.sv
module rlog_buffer
  import rlog_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int LOG_DEPTH = 16,
  parameter int NUM_SLOTS = 5,
  localparam int IDX_W = $clog2(LOG_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mAppend,
  input  logic              mIsStore,
  input  logic [ADDR_W-1:0] mAddr,
  input  logic [DATA_W-1:0] mValue,
  input  logic              mCommit,
  output logic              mStall,
  input  logic              sReq,
  input  logic              sIsStore,
  input  logic [ADDR_W-1:0] sAddr,
  output logic              sValid,
  output logic [DATA_W-1:0] sValue,
  output logic              sMismatch,
  output logic              sStall,
  input  logic              sVerify,
  input  logic              sAbort
);

  logStrobe_t       strobe;
  logic [IDX_W-1:0] wrIdx, rdIdx;

  rlog_ctrl #(.LOG_DEPTH(LOG_DEPTH), .NUM_SLOTS(NUM_SLOTS)) uCtrl (
    .clk(clk), .rstN(rstN), .mAppend(mAppend), .mCommit(mCommit),
    .sReq(sReq), .sIsStore(sIsStore), .sVerify(sVerify), .sAbort(sAbort),
    .mStall(mStall), .sStall(sStall), .strobe(strobe),
    .wrIdx(wrIdx), .rdIdx(rdIdx)
  );

  rlog_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOG_DEPTH(LOG_DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .mIsStore(mIsStore), .mAddr(mAddr), .mValue(mValue), .sAddr(sAddr),
    .sValid(sValid), .sValue(sValue), .sMismatch(sMismatch)
  );

endmodule

// File: rtl/rlog_buffer_chk.sv
module rlog_buffer_chk (
  input logic clk,
  input logic rstN,
  input logic mAppend,
  input logic mCommit,
  input logic mStall,
  input logic sReq,
  input logic sIsStore,
  input logic sValid,
  input logic sMismatch,
  input logic sStall,
  input logic sVerify,
  input logic sAbort
);

  AST_VALID_FROM_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    sValid |-> $past(sReq && !sIsStore && !sStall && !sAbort)); // R1

  AST_STORE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (sReq && sIsStore) |=> !sValid); // R2

  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (sStall && !(mCommit && !mStall)) |=> sStall); // R4

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (mStall && !sVerify && !sAbort && !mAppend) |=> mStall); // R7

  AST_MISMATCH_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    sMismatch |-> sValid); // R8

  AST_ABORT_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    sAbort |=> (sStall && !mStall)); // R9

endmodule

bind rlog_buffer rlog_buffer_chk uChk (.*);

// File: tb/sim_rlog_buffer.sv
module sim_rlog_buffer;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int SLOTS  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mAppend = 0, mIsStore = 0, mCommit = 0;
  logic [ADDR_W-1:0] mAddr = '0;
  logic [DATA_W-1:0] mValue = '0;
  logic sReq = 0, sIsStore = 0, sVerify = 0, sAbort = 0;
  logic [ADDR_W-1:0] sAddr = '0;
  logic mStall, sValid, sMismatch, sStall;
  logic [DATA_W-1:0] sValue;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  rlog_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOG_DEPTH(DEPTH), .NUM_SLOTS(SLOTS)) u0 (
    .clk(clk), .rstN(rstN), .mAppend(mAppend), .mIsStore(mIsStore), .mAddr(mAddr),
    .mValue(mValue), .mCommit(mCommit), .mStall(mStall), .sReq(sReq),
    .sIsStore(sIsStore), .sAddr(sAddr), .sValid(sValid), .sValue(sValue),
    .sMismatch(sMismatch), .sStall(sStall), .sVerify(sVerify), .sAbort(sAbort)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic mOp(input bit st, input int addr, input int val, input bit commit);
    mAppend = 1; mIsStore = st; mAddr = ADDR_W'(addr); mValue = DATA_W'(val); mCommit = commit;
    step();
    mAppend = 0; mIsStore = 0; mCommit = 0;
  endtask

  task automatic mCommitOnly();
    mCommit = 1; step(); mCommit = 0;
  endtask

  task automatic sLoad(input string req, input int addr, input int expVal, input bit expMis);
    sReq = 1; sIsStore = 0; sAddr = ADDR_W'(addr);
    step();
    sReq = 0;
    check(req, "sValid", sValid, 1);
    check(req, "sValue", sValue, expVal);
    check(req, "sMismatch", sMismatch, expMis);
  endtask

  task automatic sStore(input string req);
    sReq = 1; sIsStore = 1; step(); sReq = 0; sIsStore = 0;
    check(req, "sValid after slave store", sValid, 0);
  endtask

  task automatic verify();
    sVerify = 1; step(); sVerify = 0;
  endtask

  task automatic abortAll();
    sAbort = 1; step(); sAbort = 0;
  endtask

  task automatic testReset();
    check("R10", "mStall", mStall, 0);
    check("R10", "sStall", sStall, 1);
    check("R10", "sValid", sValid, 0);
  endtask

  task automatic testBasic();
    mOp(0, 'h100, 'hA1, 0);
    mOp(1, 'h104, 'hB2, 0);
    mOp(0, 'h108, 'hC3, 0);
    check("R4", "sStall before commit", sStall, 1);
    sReq = 1; sAddr = 'h100; step(); sReq = 0;
    check("R12", "sValid on stalled request", sValid, 0);
    mCommitOnly();
    check("R4", "sStall after commit", sStall, 0);
    sLoad("R1", 'h100, 'hA1, 0);
    sStore("R2");
    sLoad("R3", 'h108, 'hC3, 0);
    check("R4", "sStall after chunk consumed", sStall, 1);
    verify();
  endtask

  task automatic testMismatch();
    mOp(0, 'h10, 'h20, 1);
    sLoad("R8", 'h11, 'h20, 1);
    mOp(1, 'h30, 'h40, 1);
    sLoad("R8", 'h30, 'h40, 1);
    verify();
    verify();
  endtask

  task automatic testSlots();
    for (int i = 0; i < SLOTS - 1; i++) mCommitOnly();
    check("R7", "mStall below slot limit", mStall, 0);
    mCommitOnly();
    check("R7", "mStall at slot limit", mStall, 1);
    mOp(0, 'h55, 'h77, 1);
    verify();
    check("R7", "mStall after one verify", mStall, 0);
    check("R7", "sStall: stalled append ignored", sStall, 1);
    mOp(0, 'h66, 'h88, 1);
    sLoad("R7", 'h66, 'h88, 0);
    abortAll();
    check("R9", "mStall after abort", mStall, 0);
    check("R9", "sStall after abort", sStall, 1);
  endtask

  task automatic testFullAndWrap();
    for (int i = 0; i < DEPTH; i++)
      mOp(0, i, 'h1000 + i, (i == DEPTH/2 - 1) || (i == DEPTH - 1));
    check("R5", "mStall with full log", mStall, 1);
    mOp(0, 'hAA, 'hDEAD, 1);
    for (int i = 0; i < DEPTH; i++) sLoad("R3", i, 'h1000 + i, 0);
    check("R4", "sStall after all read", sStall, 1);
    check("R5", "mStall after reading only", mStall, 1);
    verify();
    check("R6", "mStall after verify", mStall, 0);
    for (int i = 0; i < DEPTH/2; i++)
      mOp(i[0], 'h200 + i, 'h5000 + i, i == DEPTH/2 - 1);
    check("R11", "mStall after wrapped fill", mStall, 1);
    for (int i = 0; i < DEPTH/2; i++) begin
      if (i[0]) sStore("R11");
      else sLoad("R11", 'h200 + i, 'h5000 + i, 0);
    end
    verify();
    verify();
    check("R6", "mStall all verified", mStall, 0);
  endtask

  task automatic testEmptyVerify();
    verify();
    for (int i = 0; i < SLOTS - 1; i++) mCommitOnly();
    check("R13", "mStall below limit after idle verify", mStall, 0);
    mCommitOnly();
    check("R13", "mStall at limit after idle verify", mStall, 1);
    abortAll();
    mOp(0, 'h321, 'h654, 1);
    sLoad("R9", 'h321, 'h654, 0);
    abortAll();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    #1;
    testReset();
    testBasic();
    testMismatch();
    testSlots();
    testFullAndWrap();
    testEmptyVerify();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule